// File: doc/BRIEF.md
# Double-Buffered Fine-Resolution PWM Generator

This block produces a pulse-width modulated output from an 8-bit period count, a selectable prescaler and a 10-bit duty value. The duty value is resolved in input-clock units scaled by the prescaler rather than in whole timer ticks, because the period counter carries a 2-bit sub-count below the 8-bit period field. Every period starts with the output high, and a single-cycle match pulse marks the start, ready to feed an interrupt line.

Software writes period, duty and prescale values through a small register port. These writes land in shadow registers and move into the working registers together at the next period boundary. The running count can therefore never be overtaken by a smaller period value, so no period is ever lost to a full-range wrap. An enable bit holds the generator idle and low. When the bit is set, the shadow values load at once and a period starts on the next cycle.

Top module: `shadow_pwm`

## Requirements
- R1: After reset the generator is disabled, and `pwm_o` and `match_o` stay low.
- R2: With period field P and prescale factor S, one period lasts (P+1)*4*S clock cycles, measured from one `match_o` pulse to the next.
- R3: The prescale select in control bits [2:1] gives S=1 for code 0, S=4 for code 1 and S=16 for codes 2 and 3.
- R4: The duty value D is {duty-high register at address 2, control bits [5:4]}. Counting from the first cycle of a period, `pwm_o` is high for D*S cycles and then low.
- R5: If D*S is at least the period length, `pwm_o` stays high for the whole period.
- R6: If D is 0, `pwm_o` stays low for the whole period.
- R7: Writes to period (address 1), duty high (address 2) and control bits [5:1] (address 0) do not affect the running period. All of them take effect together from the next period.
- R8: If the period is lowered below the running count in mid-period, the current period still completes at its old length, and the next period uses the new value. There is no full-range dropout.
- R9: `match_o` is high for exactly one cycle, in the first cycle of each new period, whether or not an update was pending.
- R10: While control bit 0 (enable) is low, `pwm_o` is low and the counters hold at zero. Setting the bit loads the shadow values, and a period starts in the next cycle with `pwm_o` high when D>0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 control, 1 period, 2 duty high, 3 ignored |
| wr_data_i | input | 8 | Write data |
| pwm_o | output | 1 | PWM output |
| match_o | output | 1 | One-cycle period-start pulse |

## Verification
Each measured period is compared against its expected length and high time. The settings cover all three prescale factors, a zero duty, a duty exactly equal to the period and the largest duty. These settings separate a wrong prescale decode, a duty compare in coarse ticks and a missing saturation. Retunes written in the first cycles of a period show whether shadowing holds the old values for the running period and swaps all fields together. A long period cut to a short one late in the count tells the buffered behaviour apart from a wrap dropout. Disabled intervals and the first period after enable check idle gating and the immediate start.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  parameter int unsigned PER_W  = 8;
  parameter int unsigned SUB_W  = 2;
  parameter int unsigned PRE_W  = 4;
  parameter int unsigned DUTY_W = PER_W + SUB_W;

  // control byte fields
  parameter int unsigned CTRL_EN    = 0;
  parameter int unsigned CTRL_PS_LO = 1;
  parameter int unsigned CTRL_DL_LO = 4;

  typedef enum logic [1:0] {
    REG_CTRL    = 2'd0,
    REG_PERIOD  = 2'd1,
    REG_DUTY_HI = 2'd2,
    REG_SPARE   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PER_W-1:0]  period;
    logic [DUTY_W-1:0] duty;
    logic [1:0]        ps_sel;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import shadow_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       boundary_i,
  output pwm_cfg_t   cfg_o,
  output logic       en_o
);
  pwm_cfg_t sh_q, sh_d, act_q;
  logic     pend_q, pend_d, en_q, en_d, start, load;
  logic     unused_bits;

  assign unused_bits = ^{wr_data_i[7:6], wr_data_i[3]};

  always_comb begin
    sh_d   = sh_q;
    pend_d = pend_q;
    en_d   = en_q;
    if (wr_en_i) begin
      unique case (reg_sel_e'(wr_addr_i))
        REG_CTRL: begin
          en_d                     = wr_data_i[CTRL_EN];
          sh_d.ps_sel              = wr_data_i[CTRL_PS_LO +: 2];
          sh_d.duty[SUB_W-1:0]     = wr_data_i[CTRL_DL_LO +: SUB_W];
          pend_d                   = 1'b1;
        end
        REG_PERIOD: begin
          sh_d.period = wr_data_i[PER_W-1:0];
          pend_d      = 1'b1;
        end
        REG_DUTY_HI: begin
          sh_d.duty[DUTY_W-1:SUB_W] = wr_data_i[PER_W-1:0];
          pend_d                    = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign start = en_d && !en_q;
  // a write landing on the boundary edge is taken into the new period
  assign load  = start || (boundary_i && pend_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      en_q   <= en_d;
      pend_q <= load ? 1'b0 : pend_d;
      if (load) act_q <= sh_d;
    end
  end

  assign cfg_o = act_q;
  assign en_o  = en_q;

  p_act_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !boundary_i) |=> $stable(act_q));
  p_pend_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && pend_q) |=> !pend_q);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import shadow_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [1:0]        ps_sel_i,
  output logic [DUTY_W-1:0] pos_o,
  output logic              boundary_o
);
  logic [PRE_W-1:0]  pre_q, pre_lim;
  logic [DUTY_W-1:0] pos_q, pos_last;
  logic              step;

  always_comb begin
    unique case (ps_sel_i)
      2'd0:    pre_lim = PRE_W'(0);
      2'd1:    pre_lim = PRE_W'(3);
      default: pre_lim = PRE_W'(15);
    endcase
  end

  assign pos_last   = {period_i, {SUB_W{1'b1}}};
  assign step       = (pre_q == pre_lim);
  assign boundary_o = en_i && step && (pos_q == pos_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      pos_q <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
      pos_q <= '0;
    end else if (step) begin
      pre_q <= '0;
      pos_q <= boundary_o ? '0 : pos_q + DUTY_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  assign pos_o = pos_q;

  p_no_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (pos_q <= pos_last));
  p_phase_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> (pos_q == '0 && pre_q == '0));
endmodule

// File: rtl/pwm_output.sv
module pwm_output
  import shadow_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] pos_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              boundary_i,
  output logic              pwm_o,
  output logic              match_o
);
  logic match_q;

  assign pwm_o = en_i && (pos_i < duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) match_q <= 1'b0;
    else         match_q <= boundary_i;
  end

  assign match_o = match_q;

  p_match_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_q |=> !match_q);
  p_period_opens_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_q && en_i) |-> (pwm_o == (duty_i != '0)));
  p_idle_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !pwm_o);
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic       pwm_o,
  output logic       match_o
);
  pwm_cfg_t          cfg;
  logic              en, boundary;
  logic [DUTY_W-1:0] pos;

  pwm_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .boundary_i (boundary),
    .cfg_o      (cfg),
    .en_o       (en)
  );

  pwm_timebase u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .period_i   (cfg.period),
    .ps_sel_i   (cfg.ps_sel),
    .pos_o      (pos),
    .boundary_o (boundary)
  );

  pwm_output u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .pos_i      (pos),
    .duty_i     (cfg.duty),
    .boundary_i (boundary),
    .pwm_o      (pwm_o),
    .match_o    (match_o)
  );

  p_reset_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!pwm_o && !match_o));
endmodule

// File: tb/sim_shadow_pwm.sv
module sim_shadow_pwm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pwm, match;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int pending_n = 0;
  int dbl = 0;
  bit tb_en = 1'b0;
  bit done = 1'b0;

  int    q_len[$];
  int    q_hi[$];
  string q_tag[$];

  int cur_p, cur_sel, cur_duty;

  always #5 clk = ~clk;

  shadow_pwm u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .pwm_o     (pwm),
    .match_o   (match)
  );

  function automatic int ps_of(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  function automatic logic [7:0] ctrl(input bit en, input int sel, input int dl);
    return {2'b00, 2'(dl), 1'b0, 2'(sel), en};
  endfunction

  task automatic push_exp(input int p, input int sel, input int duty, input string tag);
    int len, hi;
    len = (p + 1) * 4 * ps_of(sel);
    hi  = duty * ps_of(sel);
    if (hi > len) hi = len;
    q_len.push_back(len);
    q_hi.push_back(hi);
    q_tag.push_back(tag);
    pending_n++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called in the first cycle of a period: old item, shadow writes, new items
  task automatic retune(input int p, input int sel, input int dh, input int dl,
                        input int n, input int delay, input string tag);
    push_exp(cur_p, cur_sel, cur_duty, tag);
    repeat (delay) @(negedge clk);
    wr(2'd1, 8'(p));
    wr(2'd2, 8'(dh));
    wr(2'd0, ctrl(1'b1, sel, dl));
    cur_p = p; cur_sel = sel; cur_duty = dh * 4 + dl;
    for (int i = 0; i < n; i++) push_exp(cur_p, cur_sel, cur_duty, tag);
    wait (pending_n == 0);
  endtask

  // monitor: measures each period between match pulses and pops the scoreboard
  bit meas = 1'b0;
  bit prev_m = 1'b0;
  int m_len = 0;
  int m_hi = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!tb_en) begin
        meas = 1'b0; prev_m = 1'b0;
      end else begin
        if (match && prev_m) dbl++;
        prev_m = match;
        if (match) begin
          if (meas && q_len.size() > 0) begin
            int el, eh;
            string t;
            el = q_len.pop_front(); eh = q_hi.pop_front(); t = q_tag.pop_front();
            checks++;
            if (m_len != el || m_hi != eh) begin
              errors++;
              $display("FAIL %s: len=%0d high=%0d expected len=%0d high=%0d",
                       t, m_len, m_hi, el, eh);
            end
            pending_n--;
          end
          meas = 1'b1; m_len = 1; m_hi = int'(pwm);
        end else if (meas) begin
          m_len++; m_hi += int'(pwm);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int bad, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset
    bad = 0;
    repeat (8) begin @(negedge clk); bad += int'(pwm) + int'(match); end
    check(bad == 0, "R1 idle after reset", bad, 0);

    // R10: shadows written while disabled, output stays idle
    wr(2'd1, 8'd4);
    wr(2'd2, 8'd2);
    wr(2'd0, ctrl(1'b0, 0, 1));
    bad = 0;
    repeat (20) begin @(negedge clk); bad += int'(pwm) + int'(match); end
    check(bad == 0, "R10 disabled idle", bad, 0);

    // R10: enable starts a period at once (P=4, S=1, D=9)
    wr(2'd0, ctrl(1'b1, 0, 1));
    tb_en = 1'b1;
    check(pwm == 1'b1, "R10 high at start", int'(pwm), 1);
    n = 0;
    while (!match) begin @(negedge clk); n++; end
    check(n == 20, "R10 R2 first period length", n, 20);
    cur_p = 4; cur_sel = 0; cur_duty = 9;

    for (int i = 0; i < 3; i++) push_exp(cur_p, cur_sel, cur_duty, "R2 R4 R9");
    wait (pending_n == 0);

    retune(3,   1, 2,   2, 2, 0,   "R3 R7");
    retune(1,   2, 0,   3, 2, 0,   "R3");
    retune(1,   3, 0,   3, 1, 0,   "R3");
    retune(2,   0, 0,   0, 2, 0,   "R6");
    retune(2,   0, 3,   0, 2, 0,   "R5");
    retune(2,   0, 255, 3, 1, 0,   "R5");
    retune(150, 0, 75,  0, 1, 0,   "R7");
    retune(10,  0, 5,   0, 2, 500, "R8");

    check(dbl == 0, "R9 single-cycle match", dbl, 0);

    // R10: disable returns to idle
    tb_en = 1'b0;
    wr(2'd0, ctrl(1'b0, 0, 0));
    @(negedge clk);
    bad = 0;
    repeat (20) begin @(negedge clk); bad += int'(pwm) + int'(match); end
    check(bad == 0, "R10 idle after disable", bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule